// File: doc/BRIEF.md
# Timer Channel with Capture, Compare and PWM

This block is a single channel of a general-purpose timer. A shared free-running counter, which lies outside the block, supplies its count value and period. Software picks one of four behaviours through a control/status register. In capture mode a chosen edge on the pin records the count. In compare mode a counter match drives the pin to a chosen level. In edge-aligned or center-aligned PWM mode the pin carries a pulse whose width is set by the channel value. A chip-level center-aligned select overrides the mode bits and forces center-aligned PWM.

Each capture or match event sets a channel flag. The flag raises an interrupt request when its enable is set. Software clears the flag with a two-step handshake: it first reads the status while the flag is set, then writes a 0 to the flag bit. If a new event arrives before that write, the handshake starts again, so an event cannot be lost. When the duty is 0% or 100% in PWM mode, a match does not set the flag. With the edge/level field at 00 the pin goes back to general-purpose I/O. In that state the channel can still run as a software timer that only raises its flag.

Top module: `tmr_chan`

## Requirements
- R1: After a synchronous reset, `sc_rdata`, `val_rdata`, `pin_out`, `pin_own` and `irq` are all 0.
- R2: `sc_rdata` reads bit 7 as the flag, bit 6 as the interrupt enable, bit 5 as mode B, bit 4 as mode A, bits 3:2 as the edge/level field, and bits 1:0 as 0. A write to `sc_wdata` loads bits 6:2. With `center_sel`=0, mode B=1 selects edge-aligned PWM, B:A=01 selects compare and B:A=00 selects capture. With `center_sel`=1 the channel is in center-aligned PWM whatever the mode bits are.
- R3: In capture mode the edge field selects the edge: 01 rising, 10 falling, 11 both. A pin change applied before clock edge k passes a two-stage synchronizer and sets the flag at edge k+2. At that edge `val_rdata` takes the `cnt_val` present at edge k+2.
- R4: In compare or PWM mode, `cnt_val` equal to the channel value at an edge sets the flag at that edge.
- R5: In PWM mode, a channel value of 0 or a channel value above `cnt_period` never sets the flag.
- R6: In compare mode a match updates `pin_out` at the same edge as the flag. The action is set by the edge field: 01 toggles, 10 drives 0, 11 drives 1.
- R7: In PWM mode `pin_out` after edge k equals (`cnt_val` < channel value) at edge k when the edge field is 10, and the inverse of that when the field is 01 or 11.
- R8: When the edge field is 00, `pin_own` is 0, `pin_out` holds its value, and pin edges in capture mode are ignored (flag and value unchanged). A compare match still sets the flag.
- R9: The flag clears only when a write with bit 7=0 follows a read that saw the flag at 1. A clearing write with no prior read, or a write with bit 7=1, leaves the flag set.
- R10: An event between the read and the clearing write, or in the same cycle as that write, keeps the flag at 1.
- R11: `irq` equals flag AND interrupt enable in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_period | input | CNT_W | Shared counter period (top count) |
| center_sel | input | 1 | Center-aligned PWM select from the timer |
| sc_rd | input | 1 | Read strobe for the control/status register |
| sc_wr | input | 1 | Write strobe for the control/status register |
| sc_wdata | input | 8 | Control/status write data |
| sc_rdata | output | 8 | Control/status read data |
| val_wr | input | 1 | Write strobe for the channel value |
| val_wdata | input | CNT_W | Channel value write data |
| val_rdata | output | CNT_W | Channel value read data |
| pin_in | input | 1 | Asynchronous pin input |
| pin_out | output | 1 | Pin drive level |
| pin_own | output | 1 | 1 when the timer owns the pin, 0 when the pin is returned to general I/O |
| irq | output | 1 | Channel interrupt request |

## Verification
Two functions can land in the same clock cycle: a flag-setting event and the software write that should clear the flag. The bench creates this collision in two ways. In the first, it places a compare match between the status read and the clearing write. In the second, it drives the match together with the clearing write in the same cycle. Each time it checks that the flag is still set afterwards. It also checks that a full read-then-write sequence with no event in between does clear the flag.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int SC_W    = 8;
  localparam int B_FLAG  = 7;
  localparam int B_IE    = 6;
  localparam int B_MB    = 5;
  localparam int B_MA    = 4;
  localparam int B_EL_HI = 3;
  localparam int B_EL_LO = 2;

  typedef enum logic [1:0] {
    MD_CAPT = 2'd0,
    MD_CMP  = 2'd1,
    MD_EPWM = 2'd2,
    MD_CPWM = 2'd3
  } chan_mode_e;

  function automatic chan_mode_e mode_decode(input logic center, input logic mb, input logic ma);
    if (center)  return MD_CPWM;
    else if (mb) return MD_EPWM;
    else if (ma) return MD_CMP;
    else         return MD_CAPT;
  endfunction
endpackage

// File: rtl/tmr_chan_sync.sv
module tmr_chan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sh[0] <= 1'b0;
        else     sh[0] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sh[i] <= 1'b0;
        else     sh[i] <= sh[i-1];
      end
    end
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag (
  input  logic clk,
  input  logic rst,
  input  logic ev,
  input  logic rd,
  input  logic wr,
  input  logic wbit,
  output logic flag,
  output logic flag_d,
  output logic armed
);
  logic armed_d;

  always_comb begin
    flag_d  = flag;
    armed_d = armed;
    if (ev) begin
      flag_d  = 1'b1;
      armed_d = 1'b0;
    end else if (wr) begin
      if (armed && !wbit) flag_d = 1'b0;
      armed_d = 1'b0;
    end else if (rd && flag) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag  <= flag_d;
      armed <= armed_d;
    end
  end
endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  chan_mode_e mode,
  input  logic [1:0] els,
  input  logic       match,
  input  logic       below,
  output logic       pin_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
    end else if (els != 2'b00) begin
      unique case (mode)
        MD_CMP: begin
          if (match) begin
            unique case (els)
              2'b01:   pin_out <= ~pin_out;
              2'b10:   pin_out <= 1'b0;
              default: pin_out <= 1'b1;
            endcase
          end
        end
        MD_EPWM, MD_CPWM: pin_out <= els[0] ? ~below : below;
        default: pin_out <= pin_out;
      endcase
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cnt_period,
  input  logic             center_sel,
  input  logic             sc_rd,
  input  logic             sc_wr,
  input  logic [SC_W-1:0]  sc_wdata,
  output logic [SC_W-1:0]  sc_rdata,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  output logic [CNT_W-1:0] val_rdata,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_own,
  output logic             irq
);
  logic             ie_q, mb_q, ma_q;
  logic [1:0]       els_q;
  logic [CNT_W-1:0] val_q;
  logic             flag, flag_d, armed;
  logic             rise, fall;
  logic             match, below, pwm_mode, duty_edge;
  logic             cap_ev, cmp_ev, ev;
  logic             ie_d;
  logic             sc_unused;
  chan_mode_e       mode;

  assign sc_unused = ^sc_wdata[1:0];

  assign mode      = mode_decode(center_sel, mb_q, ma_q);
  assign pwm_mode  = (mode == MD_EPWM) || (mode == MD_CPWM);
  assign match     = (cnt_val == val_q);
  assign below     = (cnt_val < val_q);
  assign duty_edge = (val_q == '0) || (val_q > cnt_period);
  assign cap_ev    = (mode == MD_CAPT) && ((els_q[0] && rise) || (els_q[1] && fall));
  assign cmp_ev    = (mode != MD_CAPT) && match && !(pwm_mode && duty_edge);
  assign ev        = cap_ev || cmp_ev;

  tmr_chan_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .rise(rise), .fall(fall)
  );

  tmr_chan_flag u_flag (
    .clk(clk), .rst(rst), .ev(ev), .rd(sc_rd), .wr(sc_wr),
    .wbit(sc_wdata[B_FLAG]), .flag(flag), .flag_d(flag_d), .armed(armed)
  );

  tmr_chan_out u_out (
    .clk(clk), .rst(rst), .mode(mode), .els(els_q),
    .match(match), .below(below), .pin_out(pin_out)
  );

  assign ie_d = sc_wr ? sc_wdata[B_IE] : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q  <= 1'b0;
      mb_q  <= 1'b0;
      ma_q  <= 1'b0;
      els_q <= 2'b00;
      irq   <= 1'b0;
    end else begin
      ie_q <= ie_d;
      irq  <= flag_d && ie_d;
      if (sc_wr) begin
        mb_q  <= sc_wdata[B_MB];
        ma_q  <= sc_wdata[B_MA];
        els_q <= sc_wdata[B_EL_HI:B_EL_LO];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         val_q <= '0;
    else if (cap_ev) val_q <= cnt_val;
    else if (val_wr) val_q <= val_wdata;
  end

  assign sc_rdata  = {flag, ie_q, mb_q, ma_q, els_q, 2'b00};
  assign val_rdata = val_q;
  assign pin_own   = |els_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             center_sel,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cnt_period,
  input logic             sc_wr,
  input logic [7:0]       sc_wdata,
  input logic [7:0]       sc_rdata,
  input logic [CNT_W-1:0] val_rdata,
  input logic             pin_out,
  input logic             irq,
  input logic             ev,
  input logic             armed
);
  p_irq_follows_r11: assert property (@(posedge clk) disable iff (rst)
    irq == (sc_rdata[7] && sc_rdata[6]));

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    sc_rdata[7] && !(sc_wr && !sc_wdata[7]) |=> sc_rdata[7]);

  p_clear_needs_read_r9: assert property (@(posedge clk) disable iff (rst)
    sc_rdata[7] && !armed |=> sc_rdata[7]);

  p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
    ev |=> sc_rdata[7]);

  p_duty_no_flag_r5: assert property (@(posedge clk) disable iff (rst)
    !sc_rdata[7] && (center_sel || sc_rdata[5]) &&
    (val_rdata == '0 || val_rdata > cnt_period) |=> !sc_rdata[7]);

  p_cmp_set_r6: assert property (@(posedge clk) disable iff (rst)
    !center_sel && sc_rdata[5:4] == 2'b01 && sc_rdata[3:2] == 2'b11 &&
    cnt_val == val_rdata |=> pin_out);

  p_gpio_hold_r8: assert property (@(posedge clk) disable iff (rst)
    sc_rdata[3:2] == 2'b00 && !sc_wr |=> $stable(pin_out));
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .center_sel(center_sel), .cnt_val(cnt_val),
  .cnt_period(cnt_period), .sc_wr(sc_wr), .sc_wdata(sc_wdata),
  .sc_rdata(sc_rdata), .val_rdata(val_rdata), .pin_out(pin_out),
  .irq(irq), .ev(ev), .armed(armed)
);

// File: tb/tb_tmr_chan.sv
module tb_tmr_chan;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] cnt_val = 8'd222;
  logic [W-1:0] cnt_period = 8'd200;
  logic         center_sel = 1'b0;
  logic         sc_rd = 1'b0, sc_wr = 1'b0;
  logic [7:0]   sc_wdata = 8'h00;
  logic [7:0]   sc_rdata;
  logic         val_wr = 1'b0;
  logic [W-1:0] val_wdata = '0;
  logic [W-1:0] val_rdata;
  logic         pin_in = 1'b0;
  logic         pin_out, pin_own, irq;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] cfg;
  logic       held;
  logic [W-1:0] vsave;

  always #10 clk = ~clk;

  tmr_chan #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_period(cnt_period),
    .center_sel(center_sel), .sc_rd(sc_rd), .sc_wr(sc_wr), .sc_wdata(sc_wdata),
    .sc_rdata(sc_rdata), .val_wr(val_wr), .val_wdata(val_wdata),
    .val_rdata(val_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_own(pin_own), .irq(irq)
  );

  // {center, edge field, channel value, counter, expected pin}
  localparam logic [19:0] PWM_VEC [13] = '{
    {1'b0, 2'b10, 8'd100, 8'd50,  1'b1},
    {1'b0, 2'b10, 8'd100, 8'd150, 1'b0},
    {1'b0, 2'b10, 8'd100, 8'd100, 1'b0},
    {1'b0, 2'b10, 8'd100, 8'd99,  1'b1},
    {1'b0, 2'b01, 8'd100, 8'd50,  1'b0},
    {1'b0, 2'b11, 8'd100, 8'd150, 1'b1},
    {1'b0, 2'b10, 8'd0,   8'd0,   1'b0},
    {1'b0, 2'b01, 8'd0,   8'd0,   1'b1},
    {1'b0, 2'b10, 8'd250, 8'd200, 1'b1},
    {1'b0, 2'b01, 8'd250, 8'd200, 1'b0},
    {1'b0, 2'b10, 8'd1,   8'd0,   1'b1},
    {1'b1, 2'b10, 8'd60,  8'd30,  1'b1},
    {1'b1, 2'b10, 8'd60,  8'd70,  1'b0}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sc_write(input logic [7:0] d);
    sc_wr = 1'b1; sc_wdata = d;
    step();
    sc_wr = 1'b0;
  endtask

  task automatic sc_read();
    sc_rd = 1'b1;
    step();
    sc_rd = 1'b0;
  endtask

  task automatic val_write(input logic [W-1:0] v);
    val_wr = 1'b1; val_wdata = v;
    step();
    val_wr = 1'b0;
  endtask

  task automatic clr();
    sc_read();
    sc_write(cfg);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    steps(3);
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 sc_rdata", sc_rdata, 0);
    chk("R1 val_rdata", val_rdata, 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_own", pin_own, 0);
    chk("R1 irq", irq, 0);

    // R2 register layout, low bits read 0
    sc_write(8'h7F);
    chk("R2 layout", sc_rdata, 8'h7C);
    chk("R8 pin_own set", pin_own, 1);
    sc_write(8'h00);

    // R7 and R2 override: PWM vector table
    foreach (PWM_VEC[i]) begin
      center_sel = PWM_VEC[i][19];
      sc_write({2'b00, ~PWM_VEC[i][19], PWM_VEC[i][19], PWM_VEC[i][18:17], 2'b00});
      val_write(PWM_VEC[i][16:9]);
      cnt_val = PWM_VEC[i][8:1];
      step();
      chk($sformatf("R7 pwm vector %0d", i), pin_out, PWM_VEC[i][0]);
    end
    center_sel = 1'b0;

    // R5 suppression, R4 PWM match
    cfg = 8'h28;
    cnt_val = 8'd222;
    sc_write(cfg);
    val_write(8'd0);
    clr();
    cnt_val = 8'd0; step(); cnt_val = 8'd222; step();
    chk("R5 zero duty no flag", sc_rdata[7], 0);
    val_write(8'd250);
    cnt_val = 8'd250; step(); cnt_val = 8'd222; step();
    chk("R5 full duty no flag", sc_rdata[7], 0);
    val_write(8'd100);
    cnt_val = 8'd100; step();
    chk("R4 pwm match flag", sc_rdata[7], 1);
    cnt_val = 8'd222;
    clr();
    chk("R9 read then write clears", sc_rdata[7], 0);

    // R6 compare actions, R4, R11
    cfg = 8'h5C;
    sc_write(cfg);
    val_write(8'd40);
    cnt_val = 8'd40; step();
    chk("R6 set action", pin_out, 1);
    chk("R4 compare flag", sc_rdata[7], 1);
    chk("R11 irq with enable", irq, 1);
    cnt_val = 8'd41;
    sc_read();
    cfg = 8'h58;
    sc_write(cfg);
    chk("R9 clear flag", sc_rdata[7], 0);
    chk("R11 irq drops", irq, 0);
    cnt_val = 8'd40; step();
    chk("R6 clear action", pin_out, 0);
    cnt_val = 8'd41;
    sc_read();
    cfg = 8'h54;
    sc_write(cfg);
    cnt_val = 8'd40; step();
    chk("R6 toggle to 1", pin_out, 1);
    cnt_val = 8'd41; step();
    cnt_val = 8'd40; step();
    chk("R6 toggle to 0", pin_out, 0);
    cnt_val = 8'd41;

    // R9 negative cases
    sc_write(cfg);
    chk("R9 write without read keeps flag", sc_rdata[7], 1);
    sc_read();
    sc_write(cfg | 8'h80);
    chk("R9 write of 1 keeps flag", sc_rdata[7], 1);
    clr();
    chk("R9 proper clear", sc_rdata[7], 0);

    // R10 event during handshake
    cnt_val = 8'd40; step(); cnt_val = 8'd41; step();
    sc_read();
    cnt_val = 8'd40; step(); cnt_val = 8'd41;
    sc_write(cfg);
    chk("R10 event between read and write", sc_rdata[7], 1);
    sc_read();
    cnt_val = 8'd40;
    sc_write(cfg);
    chk("R10 event with clearing write", sc_rdata[7], 1);
    cnt_val = 8'd41;
    clr();
    chk("R10 later clear works", sc_rdata[7], 0);

    // R8 software timer, pin released
    cfg = 8'h50;
    sc_write(cfg);
    chk("R8 pin_own released", pin_own, 0);
    held = pin_out;
    cnt_val = 8'd40; step(); cnt_val = 8'd41;
    chk("R8 software timer flag", sc_rdata[7], 1);
    chk("R8 pin holds", pin_out, held);
    clr();

    // R3 capture latency and edge select
    cfg = 8'h44;
    sc_write(cfg);
    cnt_val = 8'd77; pin_in = 1'b1; step();
    chk("R3 no flag at k", sc_rdata[7], 0);
    cnt_val = 8'd78; step();
    chk("R3 no flag at k+1", sc_rdata[7], 0);
    cnt_val = 8'd79; step();
    chk("R3 rising flag at k+2", sc_rdata[7], 1);
    chk("R3 captured count", val_rdata, 79);
    cnt_val = 8'd222;
    clr();
    pin_in = 1'b0; steps(4);
    chk("R3 falling ignored on rising select", sc_rdata[7], 0);
    cfg = 8'h48;
    sc_write(cfg);
    pin_in = 1'b1; steps(4);
    chk("R3 rising ignored on falling select", sc_rdata[7], 0);
    pin_in = 1'b0; steps(4);
    chk("R3 falling captured", sc_rdata[7], 1);
    clr();
    cfg = 8'h4C;
    sc_write(cfg);
    pin_in = 1'b1; steps(4);
    chk("R3 both edges rising", sc_rdata[7], 1);
    clr();
    pin_in = 1'b0; steps(4);
    chk("R3 both edges falling", sc_rdata[7], 1);
    clr();

    // R8 capture disabled
    cfg = 8'h40;
    sc_write(cfg);
    vsave = val_rdata;
    cnt_val = 8'd13;
    pin_in = 1'b1; steps(4);
    pin_in = 1'b0; steps(4);
    chk("R8 capture disabled flag", sc_rdata[7], 0);
    chk("R8 capture disabled value", val_rdata, vsave);

    summary();
    $finish;
  end
endmodule